// File: doc/BRIEF.md
# AUX Native Transaction Retry Controller

This block sits between a requester that wants a native register read or write over an auxiliary display channel and the low-level engine that moves the bits. The requester pulses a start strobe with a direction, a start address and a byte count. The controller latches the request and launches one engine attempt. It then sorts the engine's answer into one of two groups: retry or finish.

An engine that reports itself busy is retried on the very next cycle. A DEFER reply is retried only after a fixed pause. An ACK, a NACK, a reserved reply code or a hard engine failure ends the transaction. A full ACK ends it as success. A short ACK ends it as a protocol error. NACK and the reserved code end it as an I/O error. A hard failure ends it as an engine error, and the engine's own error code is passed through. If every one of the allowed attempts is used up on busy or DEFER answers, the transaction ends as an I/O error.

A busy flag stays high from acceptance until completion. While it is high, further start strobes are ignored, so the flag serialises access to the single engine.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, `req_busy`, `eng_go` and `cpl_valid` are low.
- R2: When `req_start` is high while idle, the request is accepted. Each attempt is a one-cycle `eng_go` pulse carrying the latched direction, address and size. `req_busy` stays high until the completion cycle. Start strobes seen while busy change neither the request presented to the engine nor the number of completions.
- R3: An engine answer with `eng_busy` high is retried with no pause: `eng_go` rises in the cycle right after the cycle in which `eng_done` was sampled. `eng_busy` takes priority over every other answer field.
- R4: A DEFER answer (`eng_reply` = 2) is followed by exactly DEFER_CYCLES idle cycles before the next `eng_go`. `eng_go` stays low throughout that pause.
- R5: At most MAX_TRIES (32) attempts are made. If the last permitted attempt ends in busy or DEFER, the transaction completes with status IO (2).
- R6: An ACK (`eng_reply` = 0) whose `eng_count` is at least the requested size completes with status OK (0), and `cpl_count` equals `eng_count`.
- R7: An ACK whose `eng_count` is below the requested size completes with status PROTO (1), and `cpl_count` equals `eng_count`.
- R8: A NACK (`eng_reply` = 1) or the reserved reply code 3 completes with status IO (2) and `cpl_count` 0.
- R9: `eng_fail` high without `eng_busy` completes with status ENGINE_ERR (3), and `eng_fail_code` is copied to `cpl_code`. For every other status, `cpl_code` is 0.
- R10: Each accepted request yields exactly one `cpl_valid` pulse, one cycle wide. It appears in the cycle after the cycle in which the final `eng_done` was sampled, and in that same cycle `req_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken only while idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Start register address |
| req_size | input | LEN_W | Requested byte count |
| req_busy | output | 1 | Transaction in flight; new requests are blocked |
| eng_go | output | 1 | One-cycle attempt launch to the engine |
| eng_read | output | 1 | Latched direction |
| eng_addr | output | ADDR_W | Latched address |
| eng_size | output | LEN_W | Latched byte count |
| eng_done | input | 1 | Engine answer valid for one cycle |
| eng_busy | input | 1 | Engine could not start; retry at once |
| eng_fail | input | 1 | Hard engine failure |
| eng_fail_code | input | ERR_W | Engine error code for a hard failure |
| eng_reply | input | 2 | Reply code: 0 ACK, 1 NACK, 2 DEFER, 3 reserved |
| eng_count | input | LEN_W | Bytes actually moved |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_status | output | 2 | 0 OK, 1 PROTO, 2 IO, 3 ENGINE_ERR |
| cpl_count | output | LEN_W | Bytes moved (OK/PROTO), else 0 |
| cpl_code | output | ERR_W | Passed-through engine error code |

## Verification
The first attempt's `eng_go` is due one cycle after the accepting edge. A retry after busy is due one cycle after the edge that samples `eng_done`. A retry after DEFER is due DEFER_CYCLES cycles later than that, and the completion pulse is due in the same cycle a busy retry would have used. The bench drives on falling edges and counts falling edges from the one where `eng_done` is withdrawn, expecting a gap of 0 after busy and DEFER_CYCLES after DEFER. It reads the completion fields at the first falling edge after the final answer and confirms at the next one that the pulse and the busy flag are gone.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_PROTO = 2'd1,
    ST_IO    = 2'd2,
    ST_ENG   = 2'd3
  } cpl_status_e;

  typedef enum logic [1:0] {
    RP_ACK   = 2'd0,
    RP_NACK  = 2'd1,
    RP_DEFER = 2'd2,
    RP_RSVD  = 2'd3
  } reply_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_PAUSE
  } state_e;

  typedef struct packed {
    logic        retry;   // attempt again
    logic        pause;   // wait the defer interval first
    cpl_status_e status;  // final status when not retrying
  } outcome_t;

  // Sort one engine answer. Busy outranks everything, then hard failure.
  function automatic outcome_t judge(input logic busy, input logic fail,
                                     input logic [1:0] reply, input logic short_ack);
    outcome_t o;
    o = '{retry: 1'b0, pause: 1'b0, status: ST_IO};
    if (busy) begin
      o.retry = 1'b1;
    end else if (fail) begin
      o.status = ST_ENG;
    end else begin
      case (reply)
        RP_ACK:   o.status = short_ack ? ST_PROTO : ST_OK;
        RP_DEFER: begin o.retry = 1'b1; o.pause = 1'b1; end
        default:  o.status = ST_IO;
      endcase
    end
    return o;
  endfunction

endpackage

// File: rtl/aux_outcome_class.sv
module aux_outcome_class
  import aux_retry_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             eng_busy,
  input  logic             eng_fail,
  input  logic [1:0]       eng_reply,
  input  logic [LEN_W-1:0] eng_count,
  input  logic [LEN_W-1:0] want_size,
  output outcome_t         outcome
);
  logic short_ack;
  assign short_ack = (eng_count < want_size);
  assign outcome   = judge(eng_busy, eng_fail, eng_reply, short_ack);
endmodule

// File: rtl/aux_try_counter.sv
module aux_try_counter #(
  parameter int MAX_TRIES = 32,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [TRY_W-1:0] tries,
  output logic             exhausted
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) tries <= '0;
    else if (bump && tries < TRY_W'(MAX_TRIES)) tries <= tries + 1'b1;
  end
  assign exhausted = (tries >= TRY_W'(MAX_TRIES));
endmodule

// File: rtl/aux_defer_timer.sv
module aux_defer_timer #(
  parameter int DEFER_CYCLES = 64,
  localparam int TMR_W       = $clog2(DEFER_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  logic [TMR_W-1:0] left;
  always_ff @(posedge clk) begin
    if (!rst_n) left <= '0;
    else if (load) left <= TMR_W'(DEFER_CYCLES);
    else if (run && left != '0) left <= left - 1'b1;
  end
  assign expired = run && (left == TMR_W'(1));
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int LEN_W        = 5,
  parameter int ERR_W        = 4,
  parameter int MAX_TRIES    = 32,
  parameter int DEFER_CYCLES = 64,
  localparam int TRY_W       = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_size,
  output logic              req_busy,
  output logic              eng_go,
  output logic              eng_read,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [LEN_W-1:0]  eng_size,
  input  logic              eng_done,
  input  logic              eng_busy,
  input  logic              eng_fail,
  input  logic [ERR_W-1:0]  eng_fail_code,
  input  logic [1:0]        eng_reply,
  input  logic [LEN_W-1:0]  eng_count,
  output logic              cpl_valid,
  output logic [1:0]        cpl_status,
  output logic [LEN_W-1:0]  cpl_count,
  output logic [ERR_W-1:0]  cpl_code
);
  state_e state;

  // named internal events
  logic             accept, resolve, in_defer, finish, start_pause;
  logic             exhausted, defer_expired;
  logic [TRY_W-1:0] tries;
  outcome_t         outcome;
  cpl_status_e      fin_status;

  assign accept      = req_start && (state == S_IDLE);
  assign eng_go      = (state == S_ISSUE);
  assign resolve     = (state == S_WAIT) && eng_done;
  assign in_defer    = (state == S_PAUSE);
  assign finish      = resolve && (!outcome.retry || exhausted);
  assign start_pause = resolve && outcome.retry && outcome.pause && !exhausted;
  assign fin_status  = outcome.retry ? ST_IO : outcome.status;
  assign req_busy    = (state != S_IDLE);

  aux_outcome_class #(.LEN_W(LEN_W)) u_class (
    .eng_busy (eng_busy),
    .eng_fail (eng_fail),
    .eng_reply(eng_reply),
    .eng_count(eng_count),
    .want_size(eng_size),
    .outcome  (outcome)
  );

  aux_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .bump     (eng_go),
    .tries    (tries),
    .exhausted(exhausted)
  );

  aux_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_pause),
    .run    (in_defer),
    .expired(defer_expired)
  );

  // request latch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_read <= 1'b0;
      eng_addr <= '0;
      eng_size <= '0;
    end else if (accept) begin
      eng_read <= req_read;
      eng_addr <= req_addr;
      eng_size <= req_size;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (accept) state <= S_ISSUE;
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            if (finish)           state <= S_IDLE;
            else if (start_pause) state <= S_PAUSE;
            else                  state <= S_ISSUE;
          end
        end
        S_PAUSE: if (defer_expired) state <= S_ISSUE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // completion register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid  <= 1'b0;
      cpl_status <= ST_OK;
      cpl_count  <= '0;
      cpl_code   <= '0;
    end else begin
      cpl_valid <= finish;
      if (finish) begin
        cpl_status <= fin_status;
        cpl_count  <= (fin_status == ST_OK || fin_status == ST_PROTO) ? eng_count : '0;
        cpl_code   <= (fin_status == ST_ENG) ? eng_fail_code : '0;
      end
    end
  end

endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
  parameter int ADDR_W    = 20,
  parameter int TRY_W     = 6,
  parameter int MAX_TRIES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_busy,
  input logic              eng_go,
  input logic [ADDR_W-1:0] eng_addr,
  input logic              eng_done,
  input logic              eng_busy,
  input logic              eng_fail,
  input logic [1:0]        eng_reply,
  input logic              cpl_valid,
  input logic [1:0]        cpl_status,
  input logic              in_defer,
  input logic [TRY_W-1:0]  tries
);
  p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);
  p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> req_busy);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_busy && $past(req_busy)) |-> $stable(eng_addr));
  p_defer_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_defer |-> !eng_go);
  p_try_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRIES));
  p_ok_from_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status == 2'd0) |-> $past(eng_reply == 2'd0 && !eng_busy && !eng_fail));
  p_eng_from_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status == 2'd3) |-> $past(eng_fail && !eng_busy));
  p_cpl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);
  p_cpl_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> ($past(eng_done) && !req_busy));
endmodule

bind aux_retry_ctrl aux_retry_chk #(
  .ADDR_W(ADDR_W), .TRY_W(TRY_W), .MAX_TRIES(MAX_TRIES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_busy  (req_busy),
  .eng_go    (eng_go),
  .eng_addr  (eng_addr),
  .eng_done  (eng_done),
  .eng_busy  (eng_busy),
  .eng_fail  (eng_fail),
  .eng_reply (eng_reply),
  .cpl_valid (cpl_valid),
  .cpl_status(cpl_status),
  .in_defer  (in_defer),
  .tries     (tries)
);

// File: tb/aux_retry_ctrl_tb.sv
module aux_retry_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D   = 64;
  localparam int MAX = 32;
  localparam int K_ACK = 0, K_NACK = 1, K_DEFER = 2, K_RSVD = 3, K_BUSY = 4, K_FAIL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_read = 1'b0;
  logic [19:0] req_addr = '0;
  logic [4:0]  req_size = '0;
  logic        req_busy, eng_go, eng_read;
  logic [19:0] eng_addr;
  logic [4:0]  eng_size;
  logic        eng_done = 1'b0, eng_busy = 1'b0, eng_fail = 1'b0;
  logic [3:0]  eng_fail_code = '0;
  logic [1:0]  eng_reply = '0;
  logic [4:0]  eng_count = '0;
  logic        cpl_valid;
  logic [1:0]  cpl_status;
  logic [4:0]  cpl_count;
  logic [3:0]  cpl_code;

  int errors = 0, checks = 0;
  int kind [0:63];
  int val  [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_retry_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected result from the retry rules
  task automatic predict(input int size, output int st, output int cnt, output int code,
                         output int att, output string tag);
    st = 2; cnt = 0; code = 0; att = MAX; tag = "R5";
    for (int i = 0; i < MAX; i++) begin
      if (kind[i] == K_BUSY || kind[i] == K_DEFER) continue;
      att = i + 1;
      case (kind[i])
        K_ACK: begin
          st = (val[i] < size) ? 1 : 0; cnt = val[i];
          tag = (st == 1) ? "R7" : "R6";
        end
        K_FAIL: begin st = 3; code = val[i]; tag = "R9"; end
        default: begin st = 2; tag = "R8"; end
      endcase
      return;
    end
  endtask

  task automatic run_txn(input int size, input bit rd, input logic [19:0] addr, input bit poke);
    int st, cnt, code, eatt, att, gap, egap, k;
    string tag;
    bit fin;
    predict(size, st, cnt, code, eatt, tag);
    @(negedge clk);
    req_start = 1'b1; req_read = rd; req_addr = addr; req_size = 5'(size);
    @(negedge clk);
    req_start = 1'b0;
    chk(req_busy === 1'b1, "R2", "busy after accept", int'(req_busy), 1);
    att = 0; egap = 0; fin = 0;
    while (!fin) begin
      gap = 0;
      while (!eng_go && gap < D + 4) begin @(negedge clk); gap++; end
      chk(eng_go === 1'b1 && gap == egap, (egap == 0) ? "R3" : "R4", "go gap", gap, egap);
      chk(eng_addr === addr && eng_size === 5'(size) && eng_read === rd, "R2", "latched addr",
          int'(eng_addr), int'(addr));
      if (poke) begin req_start = 1'b1; req_addr = ~addr; end
      @(negedge clk);
      chk(eng_go === 1'b0, "R2", "go width", int'(eng_go), 0);
      k = kind[att];
      eng_done  = 1'b1;
      eng_busy  = (k == K_BUSY);
      eng_fail  = (k == K_FAIL);
      eng_reply = (k == K_NACK) ? 2'd1 : (k == K_DEFER) ? 2'd2 : (k == K_RSVD) ? 2'd3 : 2'd0;
      eng_count = 5'(val[att]);
      eng_fail_code = 4'(val[att]);
      req_start = 1'b0;
      att++;
      @(negedge clk);
      eng_done = 1'b0; eng_busy = 1'b0; eng_fail = 1'b0;
      fin = !(k == K_BUSY || k == K_DEFER) || att == MAX;
      if (!fin) begin
        chk(cpl_valid === 1'b0, "R10", "early completion", int'(cpl_valid), 0);
        egap = (k == K_DEFER) ? D : 0;
      end
      if (gap >= D + 4) fin = 1;
    end
    chk(cpl_valid === 1'b1, "R10", "completion pulse", int'(cpl_valid), 1);
    chk(cpl_status === 2'(st), tag, "status", int'(cpl_status), st);
    chk(cpl_count === 5'(cnt), tag, "count", int'(cpl_count), cnt);
    chk(cpl_code === 4'(code), "R9", "code", int'(cpl_code), code);
    chk(att == eatt, "R5", "attempts", att, eatt);
    chk(req_busy === 1'b0, "R10", "busy drop", int'(req_busy), 0);
    @(negedge clk);
    chk(cpl_valid === 1'b0 && req_busy === 1'b0, "R10", "single pulse", int'(cpl_valid), 0);
  endtask

  task automatic fill(input int k, input int v);
    for (int i = 0; i < 64; i++) begin kind[i] = k; val[i] = v; end
  endtask

  initial begin
    void'($urandom(32'h5eed_a0c1));
    repeat (3) @(negedge clk);
    chk(req_busy === 1'b0 && eng_go === 1'b0 && cpl_valid === 1'b0, "R1", "reset idle",
        int'(req_busy) + int'(eng_go) + int'(cpl_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_busy === 1'b0 && cpl_valid === 1'b0, "R1", "idle after reset", int'(req_busy), 0);

    // directed corners
    fill(K_ACK, 8);  run_txn(8, 1, 20'h00202, 0);          // R6 exact count
    fill(K_ACK, 3);  run_txn(6, 0, 20'h00100, 0);          // R7 short ack
    fill(K_NACK, 0); run_txn(4, 1, 20'h00600, 1);          // R8 with ignored starts (R2)
    fill(K_RSVD, 0); run_txn(2, 1, 20'h00010, 0);          // R8 reserved code
    fill(K_FAIL, 9); run_txn(5, 0, 20'h00300, 0);          // R9
    fill(K_BUSY, 0); run_txn(3, 1, 20'h00400, 0);          // R5 all busy
    fill(K_DEFER, 0); run_txn(3, 1, 20'h00500, 1);         // R5 all defer, R4
    fill(K_DEFER, 0); kind[31] = K_ACK; val[31] = 4;
    run_txn(4, 0, 20'h00700, 0);                            // R6 on last attempt
    fill(K_BUSY, 0); kind[2] = K_DEFER; kind[4] = K_ACK; val[4] = 16;
    run_txn(16, 1, 20'hfffff, 0);                           // R3 R4 mix

    // constrained random
    for (int t = 0; t < 25; t++) begin
      int size;
      size = 1 + int'($urandom % 16);
      for (int i = 0; i < 64; i++) begin
        int r;
        r = int'($urandom % 100);
        if      (r < 40) begin kind[i] = K_BUSY;  val[i] = 0; end
        else if (r < 70) begin kind[i] = K_DEFER; val[i] = 0; end
        else if (r < 82) begin kind[i] = K_ACK;   val[i] = size; end
        else if (r < 88) begin kind[i] = K_ACK;   val[i] = int'($urandom % size); end
        else if (r < 93) begin kind[i] = K_NACK;  val[i] = 0; end
        else if (r < 96) begin kind[i] = K_RSVD;  val[i] = 0; end
        else             begin kind[i] = K_FAIL;  val[i] = 1 + int'($urandom % 15); end
      end
      run_txn(size, 1'($urandom % 2), 20'($urandom), 1'($urandom % 2));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule